// File: doc/BRIEF.md
# Card Status Change Event Queue

This block watches the two card-detect contacts of each card socket and turns every settled change of those contacts into an event. An event says which slot changed and whether that slot now holds a card (insert) or not (remove). The events go into one small queue shared by all slots. A host reads the entry at the head and removes it with a one-cycle pop strobe.

Each slot also has a one-cycle interrupt pulse and two bits in a status register that is cleared by reading it. One status bit records a card-detect change. The other records a change from an auxiliary source that the block does not handle. A per-slot mask chooses which of the two sources may act. The intended setting enables only card-detect.

If the queue is full, a new event is thrown away and a sticky overflow flag is set. The host clears that flag by writing a one.

Top module: `csc_event_queue`

## Requirements
- R1: Each detect contact passes a two-flop synchronizer and is accepted only after it has differed from its settled value for DEB_LEN consecutive cycles. A shorter pulse produces no event, no interrupt and no status bit.
- R2: The event type is insert (head_ins_o = 1) only when both detect contacts of the slot are settled active (1). Any other combination gives a remove event (head_ins_o = 0).
- R3: Each accepted change raises irq_o[s] for exactly one cycle.
- R4: If the card-detect enable of a slot (src_en_i[2s]) is 0, a detect change of that slot queues nothing, pulses no interrupt and sets no status bit.
- R5: A pulse on aux_chg_i[s] while src_en_i[2s+1] is 1 sets status bit 2s+1 and pulses irq_o[s], but queues no event. With that enable at 0 it has no effect.
- R6: A detect event of slot s sets status bit 2s. Raising stat_rd_i for a cycle clears all status bits at the next edge. A bit set in that same cycle survives the clear.
- R7: Events leave the queue in arrival order. While the queue is non-empty and there is no pop, the head entry does not change.
- R8: The queue holds at most DEPTH (5) events for all slots together. An event that arrives when the queue is full is dropped, and the events already queued stay unchanged.
- R9: ovf_o is set by a dropped event and stays set until a cycle with ovf_clr_i = 1. If a set and a clear fall in the same cycle, the set wins.
- R10: When several slots produce events in the same cycle, the lower-numbered slot is queued first.
- R11: A pop while the queue is empty is ignored.
- R12: After reset the queue is empty, and ovf_o, stat_o and irq_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cd_a_i | input | NSLOT | First detect contact of each slot, 1 = active |
| cd_b_i | input | NSLOT | Second detect contact of each slot, 1 = active |
| aux_chg_i | input | NSLOT | One-cycle change pulse from the auxiliary source of each slot |
| src_en_i | input | 2*NSLOT | Source enables; bit 2s = detect, bit 2s+1 = auxiliary, for slot s |
| irq_o | output | NSLOT | One-cycle change interrupt for each slot |
| stat_rd_i | input | 1 | Status read strobe; clears stat_o at the next edge |
| stat_o | output | 2*NSLOT | Status; bit 2s = detect change, bit 2s+1 = auxiliary change |
| pop_i | input | 1 | Removes the head event |
| head_valid_o | output | 1 | The queue is not empty |
| head_slot_o | output | SLOT_W | Slot number of the head event |
| head_ins_o | output | 1 | Type of the head event: 1 = insert, 0 = remove |
| ovf_o | output | 1 | Sticky overflow flag |
| ovf_clr_i | input | 1 | Clears ovf_o when 1 |

## Verification
The bench sends a contact glitch shorter than the debounce window. A filter that is too short, or missing, would queue a spurious event. It moves only one contact of a slot, which a design that decides on a single contact would report as an insert. It fills the queue past five entries: a design that overwrites old entries, or never sets the sticky flag, would return the wrong sequence when popped. It also changes both slots in the same cycle, pops an empty queue, and drives a masked detect source and an auxiliary source. Wrong slot order, a corrupted pointer, or an event queued for an unhandled or masked source would each show up at the head outputs or in the status bits.

// File: rtl/csc_pkg.sv
package csc_pkg;
  // Positions of the per-slot source enables and status bits
  localparam int unsigned SRC_DET = 0;
  localparam int unsigned SRC_AUX = 1;
  localparam int unsigned SRC_N   = 2;

  typedef enum logic {
    EVT_REMOVE = 1'b0,
    EVT_INSERT = 1'b1
  } csc_evt_kind_e;
endpackage

// File: rtl/csc_pin_filter.sv
// Synchronizer plus debounce for one detect contact.
module csc_pin_filter #(
  parameter int unsigned DEB_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic chg_o
);
  localparam int unsigned CW = $clog2(DEB_LEN) + 1;

  logic [1:0]    sync_q;
  logic          stable_q, stable_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          chg_q, chg_d;

  always_comb begin
    cnt_d    = '0;
    stable_d = stable_q;
    chg_d    = 1'b0;
    if (sync_q[1] != stable_q) begin
      if (cnt_q == CW'(DEB_LEN - 1)) begin
        stable_d = sync_q[1];
        chg_d    = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      stable_q <= 1'b0;
      cnt_q    <= '0;
      chg_q    <= 1'b0;
    end else begin
      sync_q   <= {sync_q[0], pin_i};
      stable_q <= stable_d;
      cnt_q    <= cnt_d;
      chg_q    <= chg_d;
    end
  end

  assign level_o = stable_q;
  assign chg_o   = chg_q;
endmodule

// File: rtl/csc_slot_detect.sv
// Two filtered contacts per slot; change pulse and insert classification.
module csc_slot_detect #(
  parameter int unsigned DEB_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cd_a_i,
  input  logic cd_b_i,
  output logic chg_o,
  output logic ins_o
);
  logic lvl_a, lvl_b, chg_a, chg_b;

  csc_pin_filter #(.DEB_LEN(DEB_LEN)) i_flt_a (
    .clk(clk), .rst_n(rst_n), .pin_i(cd_a_i), .level_o(lvl_a), .chg_o(chg_a)
  );
  csc_pin_filter #(.DEB_LEN(DEB_LEN)) i_flt_b (
    .clk(clk), .rst_n(rst_n), .pin_i(cd_b_i), .level_o(lvl_b), .chg_o(chg_b)
  );

  assign chg_o = chg_a | chg_b;
  assign ins_o = lvl_a & lvl_b;
endmodule

// File: rtl/csc_event_fifo.sv
// Ring buffer taking up to NPUSH pushes per cycle in index order; drops when full.
module csc_event_fifo #(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned NPUSH = 2,
  parameter int unsigned DW    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPUSH-1:0]    push_i,
  input  logic [NPUSH*DW-1:0] push_data_i,
  input  logic                pop_i,
  output logic [DW-1:0]       head_o,
  output logic                valid_o,
  output logic                drop_o
);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned SW = IW + CW + 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] mem_d [DEPTH];
  logic [IW-1:0] rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   fill_c;
  logic [SW-1:0] sum_c;
  logic          pop_ok;

  assign pop_ok = pop_i && (cnt_q != '0);

  always_comb begin
    mem_d  = mem_q;
    fill_c = {1'b0, cnt_q};
    sum_c  = '0;
    drop_o = 1'b0;
    for (int i = 0; i < int'(NPUSH); i++) begin
      if (push_i[i]) begin
        if (fill_c < (CW+1)'(DEPTH)) begin
          sum_c = (SW'(rd_q) + SW'(fill_c)) % SW'(DEPTH);
          mem_d[sum_c[IW-1:0]] = push_data_i[i*DW +: DW];
          fill_c = fill_c + 1'b1;
        end else begin
          drop_o = 1'b1;
        end
      end
    end
    cnt_d = CW'(fill_c - {{CW{1'b0}}, pop_ok});
    rd_d  = rd_q;
    if (pop_ok) begin
      rd_d = (rd_q == IW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      mem_q <= mem_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  assign head_o  = mem_q[rd_q];
  assign valid_o = (cnt_q != '0);
endmodule

// File: rtl/csc_event_queue.sv
module csc_event_queue #(
  parameter int unsigned NSLOT   = 2,
  parameter int unsigned DEPTH   = 5,
  parameter int unsigned DEB_LEN = 4,
  localparam int unsigned SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int unsigned STAT_W = csc_pkg::SRC_N * NSLOT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSLOT-1:0]  cd_a_i,
  input  logic [NSLOT-1:0]  cd_b_i,
  input  logic [NSLOT-1:0]  aux_chg_i,
  input  logic [STAT_W-1:0] src_en_i,
  output logic [NSLOT-1:0]  irq_o,
  input  logic              stat_rd_i,
  output logic [STAT_W-1:0] stat_o,
  input  logic              pop_i,
  output logic              head_valid_o,
  output logic [SLOT_W-1:0] head_slot_o,
  output logic              head_ins_o,
  output logic              ovf_o,
  input  logic              ovf_clr_i
);
  import csc_pkg::*;

  localparam int unsigned DW = SLOT_W + 1;

  logic [NSLOT-1:0]    det_chg, det_ins, det_fire, aux_fire;
  logic [NSLOT*DW-1:0] push_data;
  logic [STAT_W-1:0]   stat_set, stat_q, stat_d;
  logic                ovf_q, ovf_d, drop;
  logic [DW-1:0]       head;

  for (genvar s = 0; s < int'(NSLOT); s++) begin : g_slot
    csc_evt_kind_e kind;

    csc_slot_detect #(.DEB_LEN(DEB_LEN)) i_det (
      .clk(clk), .rst_n(rst_n), .cd_a_i(cd_a_i[s]), .cd_b_i(cd_b_i[s]),
      .chg_o(det_chg[s]), .ins_o(det_ins[s])
    );

    assign kind        = det_ins[s] ? EVT_INSERT : EVT_REMOVE;
    assign det_fire[s] = det_chg[s] & src_en_i[SRC_N*s + SRC_DET];
    assign aux_fire[s] = aux_chg_i[s] & src_en_i[SRC_N*s + SRC_AUX];
    assign irq_o[s]    = det_fire[s] | aux_fire[s];
    assign push_data[s*DW +: DW] = {SLOT_W'(s), kind == EVT_INSERT};
    assign stat_set[SRC_N*s + SRC_DET] = det_fire[s];
    assign stat_set[SRC_N*s + SRC_AUX] = aux_fire[s];
  end

  csc_event_fifo #(.DEPTH(DEPTH), .NPUSH(NSLOT), .DW(DW)) i_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(det_fire), .push_data_i(push_data),
    .pop_i(pop_i), .head_o(head), .valid_o(head_valid_o), .drop_o(drop)
  );

  always_comb begin
    stat_d = (stat_rd_i ? '0 : stat_q) | stat_set;
    ovf_d  = drop | (ovf_q & ~ovf_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      ovf_q  <= ovf_d;
    end
  end

  assign stat_o      = stat_q;
  assign ovf_o       = ovf_q;
  assign head_slot_o = head[DW-1:1];
  assign head_ins_o  = head[0];
endmodule

// File: rtl/csc_event_queue_chk.sv
module csc_event_queue_chk #(
  parameter int unsigned NSLOT  = 2,
  parameter int unsigned SLOT_W = 1,
  parameter int unsigned STAT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSLOT-1:0]  irq_o,
  input logic              stat_rd_i,
  input logic [STAT_W-1:0] stat_o,
  input logic              pop_i,
  input logic              head_valid_o,
  input logic [SLOT_W-1:0] head_slot_o,
  input logic              head_ins_o,
  input logic              ovf_o,
  input logic              ovf_clr_i
);
  assert_head_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    head_valid_o && !pop_i |=> head_valid_o && $stable(head_slot_o) && $stable(head_ins_o));

  assert_empty_only_by_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    head_valid_o && !pop_i |=> head_valid_o);

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o && !ovf_clr_i |=> ovf_o);

  assert_ovf_needs_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !head_valid_o |=> !$rose(ovf_o));

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_i && (irq_o == '0) |=> stat_o == '0);
endmodule

bind csc_event_queue csc_event_queue_chk #(
  .NSLOT(NSLOT), .SLOT_W(SLOT_W), .STAT_W(STAT_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .stat_rd_i(stat_rd_i), .stat_o(stat_o),
  .pop_i(pop_i), .head_valid_o(head_valid_o), .head_slot_o(head_slot_o),
  .head_ins_o(head_ins_o), .ovf_o(ovf_o), .ovf_clr_i(ovf_clr_i)
);

// File: tb/test_csc_event_queue.sv
`timescale 1ns/1ps
module test_csc_event_queue;
  localparam int NSLOT = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cd_a = '0, cd_b = '0, aux = '0;
  logic [3:0] en = 4'b0101;
  logic [1:0] irq;
  logic       stat_rd = 1'b0, pop = 1'b0, clr = 1'b0;
  logic [3:0] stat;
  logic       hv, hslot, hins, ovf;

  int checks = 0, fails = 0;
  int irq_hi [2] = '{0, 0};
  int irq_edges [2] = '{0, 0};
  int exp_edges [2] = '{0, 0};
  logic [1:0] irq_prev = '0;
  bit done = 0;

  always #10 clk = ~clk;

  csc_event_queue i_csc_event_queue (
    .clk(clk), .rst_n(rst_n), .cd_a_i(cd_a), .cd_b_i(cd_b), .aux_chg_i(aux),
    .src_en_i(en), .irq_o(irq), .stat_rd_i(stat_rd), .stat_o(stat), .pop_i(pop),
    .head_valid_o(hv), .head_slot_o(hslot), .head_ins_o(hins), .ovf_o(ovf),
    .ovf_clr_i(clr)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      for (int s = 0; s < NSLOT; s++) begin
        if (irq[s]) irq_hi[s]++;
        if (irq[s] && !irq_prev[s]) irq_edges[s]++;
      end
      irq_prev <= irq;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk_irq(string req);
    for (int s = 0; s < NSLOT; s++) begin
      chk({req, " irq pulses"}, irq_edges[s], exp_edges[s]);
      chk({"R3 single-cycle irq"}, irq_hi[s], exp_edges[s]);
    end
  endtask

  task automatic expect_pop(string req, int slot, int ins);
    chk({req, " head valid"}, int'(hv), 1);
    chk({req, " head slot"}, int'(hslot), slot);
    chk({req, " head type"}, int'(hins), ins);
    pop = 1'b1;
    cyc(1);
    pop = 1'b0;
  endtask

  task automatic t_reset;
    chk("R12 empty", int'(hv), 0);
    chk("R12 ovf", int'(ovf), 0);
    chk("R12 stat", int'(stat), 0);
    chk("R12 irq", int'(irq), 0);
  endtask

  task automatic t_classify;
    cd_a[0] = 1'b1; cyc(12); exp_edges[0]++;
    cd_b[0] = 1'b1; cyc(12); exp_edges[0]++;
    chk("R6 detect status", int'(stat), 4'b0001);
    expect_pop("R2 one contact is remove", 0, 0);
    expect_pop("R2 both contacts is insert", 0, 1);
    chk("R7 queue drained", int'(hv), 0);
    stat_rd = 1'b1; cyc(1); stat_rd = 1'b0;
    chk("R6 read clears", int'(stat), 0);
    chk_irq("R3");
  endtask

  task automatic t_glitch;
    cd_a[1] = 1'b1; cyc(2); cd_a[1] = 1'b0; cyc(12);
    chk("R1 glitch queues nothing", int'(hv), 0);
    chk("R1 glitch sets no status", int'(stat), 0);
    chk_irq("R1");
  endtask

  task automatic t_masked;
    en = 4'b0001;
    cd_a[1] = 1'b1; cyc(12);
    chk("R4 masked queues nothing", int'(hv), 0);
    chk("R4 masked status", int'(stat), 0);
    chk_irq("R4");
    en = 4'b0101;
  endtask

  task automatic t_aux;
    en = 4'b1101;
    aux[1] = 1'b1; cyc(1); aux[1] = 1'b0; exp_edges[1]++;
    chk("R5 aux status bit", int'(stat), 4'b1000);
    chk("R5 aux queues nothing", int'(hv), 0);
    stat_rd = 1'b1; cyc(1); stat_rd = 1'b0;
    en = 4'b0101;
    aux[1] = 1'b1; cyc(1); aux[1] = 1'b0; cyc(1);
    chk("R5 masked aux status", int'(stat), 0);
    chk_irq("R5");
  endtask

  task automatic t_simultaneous;
    cd_b[0] = 1'b0; cd_b[1] = 1'b1; cyc(12);
    exp_edges[0]++; exp_edges[1]++;
    chk("R6 both detect bits", int'(stat), 4'b0101);
    expect_pop("R10 slot 0 first", 0, 0);
    expect_pop("R10 slot 1 second", 1, 1);
    chk("R10 drained", int'(hv), 0);
    stat_rd = 1'b1; cyc(1); stat_rd = 1'b0;
    chk_irq("R10");
  endtask

  task automatic t_overflow;
    int exp_kind [5];
    for (int k = 0; k < 6; k++) begin
      cd_b[0] = ~cd_b[0]; cyc(12); exp_edges[0]++;
      if (k < 5) exp_kind[k] = int'(cd_a[0] & cd_b[0]);
      if (k == 4) chk("R8 five fit without overflow", int'(ovf), 0);
    end
    chk("R8 sixth sets overflow", int'(ovf), 1);
    for (int k = 0; k < 5; k++) expect_pop("R8 retained entry", 0, exp_kind[k]);
    chk("R8 dropped event absent", int'(hv), 0);
    chk("R9 overflow sticky", int'(ovf), 1);
    clr = 1'b1; cyc(1); clr = 1'b0;
    chk("R9 overflow cleared", int'(ovf), 0);
    stat_rd = 1'b1; cyc(1); stat_rd = 1'b0;
    chk_irq("R8");
  endtask

  task automatic t_pop_empty;
    pop = 1'b1; cyc(1); pop = 1'b0; cyc(1);
    chk("R11 pop on empty", int'(hv), 0);
    cd_a[1] = 1'b0; cyc(12); exp_edges[1]++;
    expect_pop("R11 queue intact after empty pop", 1, 0);
    chk("R11 drained", int'(hv), 0);
    chk_irq("R11");
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_classify();
    t_glitch();
    t_masked();
    t_aux();
    t_simultaneous();
    t_overflow();
    t_pop_empty();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule